// File: doc/BRIEF.md
# Phy control command decoder

This block takes fixed-size binary control requests for a UART phy-selection subsystem and answers each one with a 4-byte response. Request bytes arrive on a valid/ready byte stream that carries start-of-packet and end-of-packet markers. After a request ends, the block validates it and loads a response. For an accepted set request, it also pulses an override strobe, together with the target instance and mode, toward the phy ownership arbiter. A get request reads back the current phy mode. The arbiter supplies that mode on a plain input.

A request is four bytes: subsystem id (0x06), opcode, instance index and phy value. Two opcodes are defined: set (0x00) and get (0x01). Instance 0 is the shared hardware UART and takes every phy mode. Instance 1 is a TTL-only UART. When a request fails, the response carries one status code, and the checks run in a fixed priority order.

Back-pressure rules:
- The input side deasserts `in_ready` from the cycle after the end-of-packet byte is accepted until the last response byte is accepted.
- On the output side, `out_data` and `out_last` hold steady while `out_valid` is high and `out_ready` is low.
- The output side never withdraws a byte it has offered.

Top module: `phy_cmd_decoder`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `ovr_strobe` is 0.
- R2: A packet opens with a byte accepted with `in_sop`=1 and closes with a byte accepted with `in_eop`=1. Bytes accepted while no packet is open are ignored. A new `in_sop` discards a packet that is still open. Byte positions are: 0 = subsystem id, 1 = opcode, 2 = instance index, 3 = phy value.
- R3: A packet whose byte 0 is not 0x06 produces no response and no strobe.
- R4: A packet whose length is not 4 bytes returns status 7. This check comes before all others. Missing bytes read as 0x00, so the opcode echo is 0x00 for a 1-byte packet.
- R5: If the length is correct, an opcode of 0x02 or above returns status 10. This check comes before the index check.
- R6: An instance index of 2 or more returns status 4. This check comes before the phy checks.
- R7: For a set request, a phy value above 3 returns status 2. A phy value other than 1 (TTL) on instance 1 returns status 10. The range check wins when both apply.
- R8: An accepted set request returns status 0 with byte 3 equal to the phy value. `ovr_strobe` is high for exactly one cycle, in the cycle in which `out_valid` first rises, with `ovr_inst`/`ovr_mode` giving the index and phy. A rejected request gives no strobe and byte 3 = 0x00.
- R9: A get request returns status 0. Byte 3 is `cur_phy` for instance 0 and always 1 for instance 1. The phy byte of a get request is ignored.
- R10: The response is 0x06, opcode echo, status, value, in that order. `out_last` is high only on the fourth byte.
- R11: `out_data` holds while stalled. `in_ready` is 0 while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request byte valid |
| in_ready | output | 1 | Request byte accepted when high with in_valid |
| in_data | input | 8 | Request byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Response byte consumed |
| out_data | output | 8 | Response byte |
| out_last | output | 1 | Fourth response byte |
| cur_phy | input | 2 | Current phy mode of instance 0 from the arbiter |
| ovr_strobe | output | 1 | One-cycle override pulse |
| ovr_inst | output | IDX_W (1) | Instance targeted by the override |
| ovr_mode | output | 2 | Phy mode to apply (0 off, 1 TTL, 2 RS-232, 3 RS-485) |

## Verification
The hardest cases to reach from the ports are requests that break several rules at once. These are the only way to expose the priority order. The vector table therefore carries packets such as a wrong opcode with an out-of-range index, a bad phy on the TTL-only instance, and an overlong packet with a reserved opcode. Each has exactly one correct status. Stalls in the middle of a response are forced by holding `out_ready` low for two cycles on every third vector. Other directed sequences reach the restart and stray-byte paths: a packet reopened by a second start marker, and bytes sent with no start marker.

// File: rtl/phy_cmd_pkg.sv
package phy_cmd_pkg;
  typedef enum logic [7:0] {
    ST_OK       = 8'd0,
    ST_EINVAL   = 8'd2,
    ST_ENOENT   = 8'd4,
    ST_EMSGSIZE = 8'd7,
    ST_ENOTSUP  = 8'd10
  } status_e;

  localparam logic [7:0] OP_SET = 8'h00;
  localparam logic [7:0] OP_GET = 8'h01;

  localparam logic [1:0] PHY_TTL = 2'd1;
  localparam logic [7:0] PHY_MAX = 8'd3;

  typedef struct packed {
    logic [7:0] sub;
    logic [7:0] op;
    logic [7:0] status;
    logic [7:0] value;
  } resp_t;
endpackage

// File: rtl/phy_cmd_collect.sv
module phy_cmd_collect #(
  parameter int PKT_LEN = 4,
  localparam int CNT_W = $clog2(PKT_LEN + 2)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fire,
  input  logic                      sop,
  input  logic                      eop,
  input  logic [7:0]                data,
  output logic [PKT_LEN-1:0][7:0]   pkt,
  output logic [CNT_W-1:0]          len,
  output logic                      done
);
  logic active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      len    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fire && sop) begin
        active <= !eop;
        len    <= CNT_W'(1);
        done   <= eop;
      end else if (fire && active) begin
        if (len <= CNT_W'(PKT_LEN)) len <= len + 1'b1;
        if (eop) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < PKT_LEN; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) pkt[g] <= '0;
      else if (fire && sop) pkt[g] <= (g == 0) ? data : 8'h00;
      else if (fire && active && len == CNT_W'(g)) pkt[g] <= data;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) done |-> len != '0); // R2
endmodule

// File: rtl/phy_cmd_check.sv
module phy_cmd_check
  import phy_cmd_pkg::*;
#(
  parameter int                 PKT_LEN   = 4,
  parameter logic [7:0]         SUBSYS_ID = 8'h06,
  parameter int                 NUM_INST  = 2,
  parameter logic [NUM_INST-1:0] TTL_MASK = 2'b10,
  localparam int CNT_W = $clog2(PKT_LEN + 2),
  localparam int IDX_W = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic [PKT_LEN-1:0][7:0] pkt,
  input  logic [CNT_W-1:0]        len,
  input  logic [1:0]              cur_phy,
  output logic                    drop,
  output resp_t                   resp,
  output logic                    set_ok,
  output logic [IDX_W-1:0]        set_inst,
  output logic [1:0]              set_mode
);
  logic [7:0] op, idx, phy;
  logic       idx_ok, ttl_only, is_set;
  status_e    status;

  assign op       = pkt[1];
  assign idx      = pkt[2];
  assign phy      = pkt[3];
  assign is_set   = (op == OP_SET);
  assign idx_ok   = (idx < 8'(NUM_INST));
  assign ttl_only = idx_ok && TTL_MASK[idx[IDX_W-1:0]];
  assign drop     = (pkt[0] != SUBSYS_ID);

  always_comb begin
    if (len != CNT_W'(PKT_LEN))                    status = ST_EMSGSIZE;
    else if (op > OP_GET)                          status = ST_ENOTSUP;
    else if (!idx_ok)                              status = ST_ENOENT;
    else if (is_set && phy > PHY_MAX)              status = ST_EINVAL;
    else if (is_set && ttl_only && phy != 8'(PHY_TTL)) status = ST_ENOTSUP;
    else                                           status = ST_OK;
  end

  always_comb begin
    resp.sub    = SUBSYS_ID;
    resp.op     = op;
    resp.status = status;
    if (status != ST_OK)  resp.value = 8'h00;
    else if (is_set)      resp.value = phy;
    else if (ttl_only)    resp.value = 8'(PHY_TTL);
    else                  resp.value = {6'b0, cur_phy};
  end

  assign set_ok   = !drop && is_set && (status == ST_OK);
  assign set_inst = idx[IDX_W-1:0];
  assign set_mode = phy[1:0];
endmodule

// File: rtl/phy_cmd_resp.sv
module phy_cmd_resp
  import phy_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  resp_t      resp_in,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last
);
  resp_t      held;
  logic [1:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= '0;
      pos       <= '0;
      out_valid <= 1'b0;
    end else if (load) begin
      held      <= resp_in;
      pos       <= '0;
      out_valid <= 1'b1;
    end else if (out_valid && out_ready) begin
      if (pos == 2'd3) out_valid <= 1'b0;
      else             pos       <= pos + 1'b1;
    end
  end

  always_comb begin
    case (pos)
      2'd0:    out_data = held.sub;
      2'd1:    out_data = held.op;
      2'd2:    out_data = held.status;
      default: out_data = held.value;
    endcase
  end

  assign out_last = out_valid && (pos == 2'd3);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |=> out_valid && $stable(out_data)); // R11
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n) out_last |-> out_valid); // R10
  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) load |-> !out_valid); // R11
endmodule

// File: rtl/phy_cmd_decoder.sv
module phy_cmd_decoder
  import phy_cmd_pkg::*;
#(
  parameter int                  PKT_LEN   = 4,
  parameter logic [7:0]          SUBSYS_ID = 8'h06,
  parameter int                  NUM_INST  = 2,
  parameter logic [NUM_INST-1:0] TTL_MASK  = 2'b10,
  localparam int CNT_W = $clog2(PKT_LEN + 2),
  localparam int IDX_W = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic [1:0]       cur_phy,
  output logic             ovr_strobe,
  output logic [IDX_W-1:0] ovr_inst,
  output logic [1:0]       ovr_mode
);
  logic [PKT_LEN-1:0][7:0] pkt;
  logic [CNT_W-1:0]        len;
  logic                    done, drop, set_ok, fire;
  logic [IDX_W-1:0]        set_inst;
  logic [1:0]              set_mode;
  resp_t                   resp;

  assign in_ready = !out_valid && !done;
  assign fire     = in_valid && in_ready;

  phy_cmd_collect #(.PKT_LEN(PKT_LEN)) u_collect (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sop(in_sop), .eop(in_eop),
    .data(in_data), .pkt(pkt), .len(len), .done(done)
  );

  phy_cmd_check #(
    .PKT_LEN(PKT_LEN), .SUBSYS_ID(SUBSYS_ID), .NUM_INST(NUM_INST), .TTL_MASK(TTL_MASK)
  ) u_check (
    .pkt(pkt), .len(len), .cur_phy(cur_phy), .drop(drop), .resp(resp),
    .set_ok(set_ok), .set_inst(set_inst), .set_mode(set_mode)
  );

  phy_cmd_resp u_resp (
    .clk(clk), .rst_n(rst_n), .load(done && !drop), .resp_in(resp),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_strobe <= 1'b0;
      ovr_inst   <= '0;
      ovr_mode   <= '0;
    end else begin
      ovr_strobe <= done && set_ok;
      if (done && set_ok) begin
        ovr_inst <= set_inst;
        ovr_mode <= set_mode;
      end
    end
  end

  AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !in_ready); // R11
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n) ovr_strobe |=> !ovr_strobe); // R8
  AST_STROBE_RESP: assert property (@(posedge clk) disable iff (!rst_n) ovr_strobe |-> out_valid && $rose(out_valid)); // R8
  AST_STROBE_TTL: assert property (@(posedge clk) disable iff (!rst_n) ovr_strobe && TTL_MASK[ovr_inst] |-> ovr_mode == PHY_TTL); // R7
endmodule

// File: tb/phy_cmd_decoder_test.sv
module phy_cmd_decoder_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [1:0] cur_phy = 2'd0;
  logic in_ready, out_valid, out_last, ovr_strobe;
  logic [7:0] out_data;
  logic [0:0] ovr_inst;
  logic [1:0] ovr_mode;

  int n_chk = 0, n_bad = 0, strb_cnt = 0, ov_rise = 0;
  logic [0:0] strb_inst;
  logic [1:0] strb_mode;
  logic ov_q = 1'b0;
  bit hold_bad, busy_bad, last_bad;

  always #4 clk = ~clk;

  phy_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .cur_phy(cur_phy), .ovr_strobe(ovr_strobe),
    .ovr_inst(ovr_inst), .ovr_mode(ovr_mode)
  );

  always @(posedge clk) begin
    ov_q <= out_valid;
    if (rst_n && out_valid && !ov_q) ov_rise <= ov_rise + 1;
    if (rst_n && ovr_strobe) begin
      strb_cnt  <= strb_cnt + 1;
      strb_inst <= ovr_inst;
      strb_mode <= ovr_mode;
      if (!(out_valid && !ov_q)) begin
        n_chk++; n_bad++;
        $display("FAIL R8 strobe not aligned with response start: got %b expected 1", out_valid && !ov_q);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit s, input bit e);
    @(negedge clk);
    in_valid = 1'b1; in_sop = s; in_eop = e; in_data = d;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic send_pkt(input int n, input logic [31:0] b);
    for (int i = 0; i < n; i++)
      send_byte(i < 4 ? b[31-8*i -: 8] : 8'hAA, i == 0, i == n - 1);
  endtask

  task automatic rx_resp(input bit stall, output logic [31:0] r, output bit got);
    logic [7:0] hold;
    r = '0; got = 1'b1;
    for (int k = 0; k < 4; k++) begin
      int t = 0;
      @(negedge clk);
      out_ready = 1'b0;
      while (!out_valid && t < 50) begin @(negedge clk); t++; end
      if (!out_valid) begin got = 1'b0; return; end
      if (in_ready) busy_bad = 1'b1;
      if (stall) begin
        hold = out_data;
        repeat (2) @(negedge clk);
        if (!out_valid || out_data !== hold) hold_bad = 1'b1;
      end
      if (out_last !== (k == 3)) last_bad = 1'b1;
      r = {r[23:0], out_data};
      out_ready = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  // len[54:52] bytes[51:20] cur[19:18] resp[17] status[16:9] value[8:1] strobe[0]
  localparam int NV = 18;
  localparam logic [54:0] VEC [NV] = '{
    {3'd4, 32'h06000002, 2'd0, 1'b1, 8'd0,  8'd2, 1'b1},  // R8 set inst0 RS-232
    {3'd4, 32'h06000000, 2'd1, 1'b1, 8'd0,  8'd0, 1'b1},  // R8 set off
    {3'd4, 32'h06000003, 2'd0, 1'b1, 8'd0,  8'd3, 1'b1},  // R8 set RS-485
    {3'd4, 32'h06000101, 2'd2, 1'b1, 8'd0,  8'd1, 1'b1},  // R8 set TTL on inst1
    {3'd4, 32'h06000102, 2'd0, 1'b1, 8'd10, 8'd0, 1'b0},  // R7 non-TTL on inst1
    {3'd4, 32'h06000100, 2'd0, 1'b1, 8'd10, 8'd0, 1'b0},  // R7 off on inst1
    {3'd4, 32'h06000004, 2'd0, 1'b1, 8'd2,  8'd0, 1'b0},  // R7 phy range
    {3'd4, 32'h06000105, 2'd0, 1'b1, 8'd2,  8'd0, 1'b0},  // R7 range wins over TTL-only
    {3'd4, 32'h06000209, 2'd0, 1'b1, 8'd4,  8'd0, 1'b0},  // R6 index before phy
    {3'd4, 32'h060100FF, 2'd3, 1'b1, 8'd0,  8'd3, 1'b0},  // R9 get inst0, phy byte ignored
    {3'd4, 32'h06010100, 2'd2, 1'b1, 8'd0,  8'd1, 1'b0},  // R9 get inst1 TTL
    {3'd4, 32'h06010300, 2'd0, 1'b1, 8'd4,  8'd0, 1'b0},  // R6 get bad index
    {3'd4, 32'h06050700, 2'd0, 1'b1, 8'd10, 8'd0, 1'b0},  // R5 opcode before index
    {3'd4, 32'h06800000, 2'd0, 1'b1, 8'd10, 8'd0, 1'b0},  // R5 high opcode
    {3'd3, 32'h06000000, 2'd0, 1'b1, 8'd7,  8'd0, 1'b0},  // R4 short
    {3'd5, 32'h06400902, 2'd0, 1'b1, 8'd7,  8'd0, 1'b0},  // R4 long, before opcode
    {3'd1, 32'h06000000, 2'd0, 1'b1, 8'd7,  8'd0, 1'b0},  // R4 single byte
    {3'd4, 32'h07000002, 2'd0, 1'b0, 8'd0,  8'd0, 1'b0}   // R3 foreign subsystem
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r, exp;
    bit got;
    int c0, v0;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0 && ovr_strobe === 1'b0, "R1 during reset",
        {in_ready, out_valid, ovr_strobe}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0 && ovr_strobe === 1'b0, "R1 after reset",
        {in_ready, out_valid, ovr_strobe}, 3'b100);

    for (int v = 0; v < NV; v++) begin
      logic [54:0] e;
      int n;
      e = VEC[v];
      n = int'(e[54:52]);
      cur_phy = e[19:18];
      hold_bad = 0; busy_bad = 0; last_bad = 0;
      c0 = strb_cnt; v0 = ov_rise;
      send_pkt(n, e[51:20]);
      if (e[17]) begin
        rx_resp(v % 3 == 0, r, got);
        exp = {8'h06, (n >= 2) ? e[43:36] : 8'h00, e[16:9], e[8:1]};
        chk(got && r == exp, $sformatf("R10 vector %0d response", v), r, exp);
        chk(!hold_bad && !busy_bad, $sformatf("R11 vector %0d stall/in_ready", v),
            {hold_bad, busy_bad}, 0);
        chk(!last_bad, $sformatf("R10 vector %0d out_last", v), last_bad, 0);
      end else begin
        repeat (12) @(negedge clk);
        chk(ov_rise == v0, $sformatf("R3 vector %0d no response", v), ov_rise - v0, 0);
      end
      repeat (2) @(negedge clk);
      chk(strb_cnt - c0 == int'(e[0]), $sformatf("R8 vector %0d strobe count", v),
          strb_cnt - c0, e[0]);
      if (e[0])
        chk(strb_mode == e[2:1] && strb_inst == e[28], $sformatf("R8 vector %0d strobe mode", v),
            {strb_inst, strb_mode}, {e[28], e[2:1]});
    end

    // R2: stray bytes without start marker are ignored
    v0 = ov_rise; c0 = strb_cnt;
    send_byte(8'h06, 0, 0); send_byte(8'h00, 0, 0); send_byte(8'h00, 0, 0); send_byte(8'h02, 0, 1);
    repeat (12) @(negedge clk);
    chk(ov_rise == v0 && strb_cnt == c0, "R2 stray bytes ignored", ov_rise - v0, 0);

    // R2: second start marker restarts an open packet
    send_byte(8'h06, 1, 0); send_byte(8'h00, 0, 0); send_byte(8'h01, 0, 0);
    send_pkt(4, 32'h06000003);
    rx_resp(0, r, got);
    chk(got && r == 32'h06000003, "R2 restart on new sop", r, 32'h06000003);
    repeat (2) @(negedge clk);
    chk(strb_mode == 2'd3 && strb_inst == 1'b0, "R2 restart strobe mode", strb_mode, 3);

    // R9: read-back follows cur_phy
    cur_phy = 2'd2;
    send_pkt(4, 32'h06010000);
    rx_resp(1, r, got);
    chk(got && r == 32'h06010002, "R9 get follows cur_phy", r, 32'h06010002);

    // R11: in_ready low while response waits unconsumed
    send_pkt(4, 32'h06010100);
    repeat (5) @(negedge clk);
    chk(out_valid === 1'b1 && in_ready === 1'b0, "R11 in_ready blocked while pending",
        {out_valid, in_ready}, 2'b10);
    rx_resp(0, r, got);
    chk(got && r == 32'h06010001, "R11 response after long stall", r, 32'h06010001);
    @(negedge clk);
    chk(in_ready === 1'b1, "R11 in_ready returns", in_ready, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule